// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit load-store processor core that fetches, decodes and completes one instruction in every clock cycle. It handles word loads and stores, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), a branch taken when two registers are equal, and an absolute jump. The instruction and data memories sit outside the core. The instruction port is read combinationally from the program counter. The data port is read combinationally and written on the rising clock edge.

Decoding works in two levels. A main decoder turns the 6-bit opcode into datapath strobes and a 2-bit ALU class. A second decoder combines that class with the 6-bit function field to pick a 4-bit ALU operation. Register read addresses always come from the same instruction fields. The write register and the write data each go through a multiplexer.

Top module: `cyc1_core`

## Requirements
- R1: While `rst_n` is low, the program counter is 0, so `imemAddr` reads 0x00000000.
- R2: Any instruction that is neither a jump nor a taken branch advances `imemAddr` by 4 at the next rising edge.
- R3: A register-format instruction (opcode 000000) with funct 100000 (add), 100010 (sub), 100100 (and) or 100101 (or) writes the result to the register in bits 15..11. The sources are the registers in bits 25..21 and 20..16.
- R4: Funct 101010 (slt) writes 1 when the register in bits 25..21 is less than the register in bits 20..16 as a two's-complement number, and writes 0 otherwise.
- R5: A load (opcode 100011) drives `dmemAddr` with the sum of the register in bits 25..21 and the sign-extended bits 15..0. It writes `dmemRdata` into the register in bits 20..16.
- R6: A store (opcode 101011) raises `dmemWe` for that cycle only, with the load's address rule and `dmemWdata` equal to the register in bits 20..16. It changes no register, even when bits 15..11 name one.
- R7: A branch (opcode 000100) whose two registers are equal moves the PC to PC+4 plus the sign-extended bits 15..0 shifted left by two. When they differ, the PC moves to PC+4.
- R8: A jump (opcode 000010) keeps the top four bits of PC+4, puts bits 25..0 into PC bits 27..2, and clears PC bits 1..0.
- R9: Register 0 always reads as zero. Writes that target it have no effect.
- R10: Negative 16-bit offsets are sign-extended, so loads and stores reach addresses below the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 32 | Byte address of the instruction being executed |
| imemData | input | 32 | Instruction word at `imemAddr` |
| dmemAddr | output | 32 | Byte address for a load or store |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe, written at the rising edge |
| dmemRe | output | 1 | Load in progress |
| dmemRdata | input | 32 | Load data at `dmemAddr` |

## Verification
The embedded assertions check these properties on every cycle:
- The PC stays word aligned.
- The PC takes the sequential, branch or jump successor that the strobes of the previous cycle selected.
- A store never comes with a register write.
- A register write lands in the addressed entry.
- Entry 0 of the register file holds zero.

Some behaviour only the directed scenarios can show. These are the arithmetic results, the signed comparison, sign extension of negative offsets, and a loop driven by a backward branch. The bench shows them by comparing the PC trace, every store and the final data memory against a reference instruction-level model.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int INSTR_W = 32;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } aluClassE;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } aluOpE;

  typedef struct packed {
    logic  regDst;
    logic  jump;
    logic  branch;
    logic  memRead;
    logic  memToReg;
    logic  memWrite;
    logic  aluSrc;
    logic  regWrite;
    aluOpE aluOp;
  } ctrlS;

endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlS       ctl
);

  aluClassE aluClass;
  ctrlS     mainCtl;

  // level one: opcode -> strobes and ALU class
  always_comb begin
    mainCtl  = '0;
    aluClass = CLS_ADD;
    unique case (opcode)
      OPC_REG: begin
        mainCtl.regDst   = 1'b1;
        mainCtl.regWrite = 1'b1;
        aluClass         = CLS_FUNCT;
      end
      OPC_LOAD: begin
        mainCtl.memRead  = 1'b1;
        mainCtl.memToReg = 1'b1;
        mainCtl.aluSrc   = 1'b1;
        mainCtl.regWrite = 1'b1;
      end
      OPC_STORE: begin
        mainCtl.memWrite = 1'b1;
        mainCtl.aluSrc   = 1'b1;
      end
      OPC_BEQ: begin
        mainCtl.branch = 1'b1;
        aluClass       = CLS_SUB;
      end
      OPC_JMP: mainCtl.jump = 1'b1;
      default: ;
    endcase
  end

  // level two: ALU class refined by funct
  always_comb begin
    ctl = mainCtl;
    unique case (aluClass)
      CLS_ADD: ctl.aluOp = ALU_ADD;
      CLS_SUB: ctl.aluOp = ALU_SUB;
      CLS_FUNCT: begin
        unique case (funct)
          FN_ADD:  ctl.aluOp = ALU_ADD;
          FN_SUB:  ctl.aluOp = ALU_SUB;
          FN_AND:  ctl.aluOp = ALU_AND;
          FN_OR:   ctl.aluOp = ALU_OR;
          FN_SLT:  ctl.aluOp = ALU_SLT;
          default: ctl.aluOp = ALU_AND;
        endcase
      end
      default: ctl.aluOp = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/core_regs.sv
module core_regs #(
  parameter int REG_CNT = 32,
  parameter int DW      = 32,
  localparam int AW     = $clog2(REG_CNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rAddrA,
  input  logic [AW-1:0] rAddrB,
  output logic [DW-1:0] rDataA,
  output logic [DW-1:0] rDataB,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [DW-1:0] wData
);

  logic [DW-1:0] regFile [REG_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) regFile[i] <= '0;
    end else if (we && (wAddr != '0)) begin
      regFile[wAddr] <= wData;
    end
  end

  assign rDataA = regFile[rAddrA];
  assign rDataB = regFile[rAddrB];

  AST_ZERO_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    regFile[0] == '0); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wAddr != '0) |=> regFile[$past(wAddr)] == $past(wData)); // R3

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int DW = 32
) (
  input  aluOpE         op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/core_dpath.sv
module core_dpath
  import core_pkg::*;
#(
  parameter int DW      = 32,
  parameter int REG_CNT = 32,
  localparam int AW     = $clog2(REG_CNT),
  localparam int IMM_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlS               ctl,
  input  logic [INSTR_W-1:0] instr,
  output logic [DW-1:0]      pcOut,
  output logic [DW-1:0]      dmemAddr,
  output logic [DW-1:0]      dmemWdata,
  input  logic [DW-1:0]      dmemRdata
);

  logic [DW-1:0] pc, pcNext, pcSeq, pcBr, pcJmp;
  logic [DW-1:0] immExt, rdA, rdB, aluB, aluY, wbData;
  logic [AW-1:0] rsIdx, rtIdx, rdIdx, wIdx;
  logic          aluZero, takeBr;

  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign immExt = {{(DW-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  assign wIdx   = ctl.regDst   ? rdIdx     : rtIdx;
  assign aluB   = ctl.aluSrc   ? immExt    : rdB;
  assign wbData = ctl.memToReg ? dmemRdata : aluY;

  core_regs #(.REG_CNT(REG_CNT), .DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .rAddrA (rsIdx),
    .rAddrB (rtIdx),
    .rDataA (rdA),
    .rDataB (rdB),
    .we     (ctl.regWrite),
    .wAddr  (wIdx),
    .wData  (wbData)
  );

  core_alu #(.DW(DW)) u_alu (
    .op   (ctl.aluOp),
    .a    (rdA),
    .b    (aluB),
    .y    (aluY),
    .zero (aluZero)
  );

  assign pcSeq  = pc + DW'(4);
  assign pcBr   = pcSeq + (immExt << 2);
  assign pcJmp  = {pcSeq[DW-1:28], instr[25:0], 2'b00};
  assign takeBr = ctl.branch && aluZero;

  always_comb begin
    if (ctl.jump)    pcNext = pcJmp;
    else if (takeBr) pcNext = pcBr;
    else             pcNext = pcSeq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pcNext;
  end

  assign pcOut     = pc;
  assign dmemAddr  = aluY;
  assign dmemWdata = rdB;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R2

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.jump && !(ctl.branch && aluZero)) |=> pc == $past(pc) + DW'(4)); // R2

  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.branch && aluZero) |=> pc == $past(pc) + DW'(4) + ($past(immExt) << 2)); // R7

  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jump |=> pc[27:2] == $past(instr[25:0])); // R8

  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.memWrite |-> !ctl.regWrite); // R6

endmodule

// File: rtl/cyc1_core.sv
module cyc1_core
  import core_pkg::*;
#(
  parameter int DW      = 32,
  parameter int REG_CNT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] imemAddr,
  input  logic [31:0]   imemData,
  output logic [DW-1:0] dmemAddr,
  output logic [DW-1:0] dmemWdata,
  output logic          dmemWe,
  output logic          dmemRe,
  input  logic [DW-1:0] dmemRdata
);

  ctrlS ctl;

  core_ctrl u_ctrl (
    .opcode (imemData[31:26]),
    .funct  (imemData[5:0]),
    .ctl    (ctl)
  );

  core_dpath #(.DW(DW), .REG_CNT(REG_CNT)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .instr     (imemData),
    .pcOut     (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemRdata (dmemRdata)
  );

  assign dmemWe = ctl.memWrite;
  assign dmemRe = ctl.memRead;

endmodule

// File: tb/sim_cyc1_core.sv
`timescale 1ns/1ps
module sim_cyc1_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemWe, dmemRe;

  logic [31:0] imem  [64];
  logic [31:0] dInit [64];
  logic [31:0] dmem  [64];
  logic [31:0] mreg  [32];
  logic [31:0] mdmem [64];
  logic [31:0] mpc;
  int nChk = 0, nBad = 0;

  always #4 clk = ~clk;

  cyc1_core u0 (
    .clk(clk), .rst_n(rst_n), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRe(dmemRe), .dmemRdata(dmemRdata)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) dmem <= dInit;
    else if (dmemWe) dmem[dmemAddr[7:2]] <= dmemWdata;
  end

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int idx);
    return {6'b000010, 26'(idx)};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dInit[i] = 32'h0; end
  endtask

  // reference model: one instruction per call, ports compared first
  task automatic stepModel(string tag);
    logic [31:0] ins, a, b, imm, pc4, nxt, res;
    logic [4:0]  rs, rt, rd;
    logic        isSt;
    ins = imem[mpc[7:2]];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    imm = {{16{ins[15]}}, ins[15:0]};
    a = mreg[rs]; b = mreg[rt];
    pc4 = mpc + 32'd4; nxt = pc4;
    chk(imemAddr == mpc, tag, "pc", imemAddr, mpc);
    isSt = (ins[31:26] == 6'b101011);
    chk(dmemWe == isSt, "R6", "store strobe", {31'd0, dmemWe}, {31'd0, isSt});
    case (ins[31:26])
      6'b000000: begin
        case (ins[5:0])
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          default:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        if (rd != 0) mreg[rd] = res;
      end
      6'b100011: begin
        chk(dmemAddr == a + imm, "R5", "load address", dmemAddr, a + imm);
        if (rt != 0) mreg[rt] = mdmem[(a + imm) >> 2 & 32'h3F];
      end
      6'b101011: begin
        chk(dmemAddr == a + imm, tag, "store address", dmemAddr, a + imm);
        chk(dmemWdata == b, "R6", "store data", dmemWdata, b);
        mdmem[(a + imm) >> 2 & 32'h3F] = b;
      end
      6'b000100: if (a == b) nxt = pc4 + (imm << 2);
      6'b000010: nxt = {pc4[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    mpc = nxt;
  endtask

  task automatic runProg(int nCyc, string tag);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(imemAddr == 32'h0, "R1", "pc in reset", imemAddr, 32'h0);
    mpc = 32'h0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mdmem = dInit;
    rst_n = 1'b1;
    for (int c = 0; c < nCyc; c++) begin
      stepModel(tag);
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++)
      chk(dmem[i] == mdmem[i], tag, $sformatf("dmem word %0d", i), dmem[i], mdmem[i]);
  endtask

  // R3 R4 R5: arithmetic, logic and signed compare
  task automatic testArith();
    clearProg();
    dInit[0] = 32'd7; dInit[1] = 32'hFFFF_FFFD;
    imem[0]  = encI(6'b100011, 0, 1, 0);
    imem[1]  = encI(6'b100011, 0, 2, 4);
    imem[2]  = encR(1, 2, 3, 6'b100000);
    imem[3]  = encR(1, 2, 4, 6'b100010);
    imem[4]  = encR(1, 2, 5, 6'b100100);
    imem[5]  = encR(1, 2, 6, 6'b100101);
    imem[6]  = encR(2, 1, 7, 6'b101010);
    imem[7]  = encR(1, 2, 8, 6'b101010);
    for (int k = 0; k < 6; k++) imem[8+k] = encI(6'b101011, 0, 3+k, 16 + 4*k);
    imem[14] = encJ(14);
    runProg(20, "R3");
    chk(dmem[4] == 32'd4, "R3", "add result", dmem[4], 32'd4);
    chk(dmem[5] == 32'd10, "R3", "sub result", dmem[5], 32'd10);
    chk(dmem[8] == 32'd1, "R4", "slt negative<positive", dmem[8], 32'd1);
    chk(dmem[9] == 32'd0, "R4", "slt positive<negative", dmem[9], 32'd0);
  endtask

  // R7 R8: loop with backward jump, branches taken and not taken
  task automatic testBranch();
    clearProg();
    dInit[0] = 32'd3; dInit[1] = 32'd1;
    imem[0]  = encI(6'b100011, 0, 1, 0);
    imem[1]  = encI(6'b100011, 0, 2, 4);
    imem[2]  = encR(0, 0, 3, 6'b100000);
    imem[3]  = encR(3, 2, 3, 6'b100000);
    imem[4]  = encR(1, 2, 1, 6'b100010);
    imem[5]  = encI(6'b000100, 1, 0, 1);
    imem[6]  = encJ(3);
    imem[7]  = encI(6'b000100, 1, 2, 5);
    imem[8]  = encI(6'b101011, 0, 3, 8);
    imem[9]  = encI(6'b000100, 0, 0, 2);
    imem[10] = encI(6'b101011, 0, 2, 12);
    imem[11] = encI(6'b101011, 0, 2, 12);
    imem[12] = encJ(12);
    runProg(30, "R7");
    chk(dmem[2] == 32'd3, "R8", "loop count", dmem[2], 32'd3);
    chk(dmem[3] == 32'd0, "R7", "skipped store", dmem[3], 32'd0);
  endtask

  // R9: writes to register 0 are dropped
  task automatic testZeroReg();
    clearProg();
    dInit[0] = 32'd5; dInit[2] = 32'hDEAD;
    imem[0] = encI(6'b100011, 0, 1, 0);
    imem[1] = encR(1, 1, 0, 6'b100000);
    imem[2] = encI(6'b100011, 0, 0, 0);
    imem[3] = encI(6'b101011, 0, 0, 8);
    imem[4] = encR(0, 1, 3, 6'b100000);
    imem[5] = encI(6'b101011, 0, 3, 12);
    imem[6] = encJ(6);
    runProg(10, "R9");
    chk(dmem[2] == 32'd0, "R9", "r0 after writes", dmem[2], 32'd0);
    chk(dmem[3] == 32'd5, "R9", "r0 as operand", dmem[3], 32'd5);
  endtask

  // R10 R6: negative offsets, store leaves registers untouched
  task automatic testNegOffset();
    clearProg();
    dInit[2] = 32'd40; dInit[5] = 32'h1234;
    imem[0] = encI(6'b100011, 0, 5, 8);
    imem[1] = encI(6'b100011, 0, 3, 20);
    imem[2] = encI(6'b101011, 5, 5, -8);
    imem[3] = encI(6'b100011, 5, 6, -20);
    imem[4] = encI(6'b101011, 5, 6, -4);
    imem[5] = encI(6'b101011, 0, 5, 16'h1830);
    imem[6] = encI(6'b101011, 0, 3, 52);
    imem[7] = encI(6'b000100, 3, 3, -1);
    runProg(16, "R10");
    chk(dmem[8] == 32'd40, "R10", "store below base", dmem[8], 32'd40);
    chk(dmem[9] == 32'h1234, "R10", "load below base", dmem[9], 32'h1234);
    chk(dmem[13] == 32'h1234, "R6", "register kept after store", dmem[13], 32'h1234);
  endtask

  initial begin
    #1600000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    testArith();
    testBranch();
    testZeroReg();
    testNegOffset();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule